// File: doc/BRIEF.md
# Single-Operand Shift and Swap Unit

This unit performs the four single-operand data operations of a small 16-bit microcontroller core. Two are one-place right shifts: a rotate through the carry and an arithmetic shift. The other two are a byte exchange and a sign extension from the low byte. Each cycle it accepts one operand, a two-bit operation code, a byte/word select and the current carry flag. One clock later it presents the registered result, a fresh set of overflow, negative, zero and carry flags, and a four-bit mask. The mask tells the status register which of those flags to load.

The two shifts can work on a full word or on the low byte only. In byte mode, bit 7 acts as the most significant bit and the upper byte of the result is forced to zero. The byte exchange and the sign extension always work on the whole word, so the byte/word select has no effect on them. The byte exchange changes no flags: its mask is all zero.

Top module: `shift_swap_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result`, all four flag outputs and `flag_mask` are cleared to zero on that edge.
- R2: With `op_sel` = 2'b00 (rotate through carry) in word mode, the result is `carry_in` in bit 15 followed by operand bits 15..1 in bits 14..0.
- R3: With `op_sel` = 2'b10 (arithmetic shift) in word mode, the result keeps operand bit 15 in bit 15 and holds operand bits 15..1 in bits 14..0.
- R4: With `byte_mode` = 1 and `op_sel` 2'b00 or 2'b10, the shift works on bits 7..0 with bit 7 as the top bit: either `carry_in` or operand bit 7 enters bit 7. Result bits 15..8 are zero.
- R5: With `op_sel` = 2'b01 (byte exchange), result bits 15..8 equal operand bits 7..0 and result bits 7..0 equal operand bits 15..8.
- R6: For the byte exchange, `flag_mask` is 4'b0000 and all four flag outputs are zero.
- R7: With `op_sel` = 2'b11 (sign extension), result bits 7..0 equal operand bits 7..0 and bits 15..8 are all copies of operand bit 7. `byte_mode` has no effect on the result or flags of this operation or of the byte exchange.
- R8: For the shifts and the sign extension, `flag_mask` is 4'b1111, where bit 3 = V, bit 2 = N, bit 1 = Z and bit 0 = C. V is 0, N equals the result's top bit (bit 7 in byte mode, else bit 15), and Z is 1 exactly when the result is zero.
- R9: For both shifts, C equals operand bit 0. For the sign extension, C is the inverse of Z.
- R10: The outputs change on the clock edge that samples the inputs, so there is exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 16 | Operand |
| op_sel | input | 2 | Operation: 00 rotate through carry, 01 byte exchange, 10 arithmetic shift, 11 sign extension |
| byte_mode | input | 1 | 1 selects the low-byte variant of the shifts |
| carry_in | input | 1 | Current carry flag |
| result | output | 16 | Registered result |
| flag_v | output | 1 | Overflow flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_mask | output | 4 | Flag load enables {V,N,Z,C} |

## Verification
The bench targets several corner cases, and each wrong design shows a distinct symptom:
- Byte-mode shifts with a non-zero upper operand byte. A design that forgot to clear the high byte would pass operand bits into result bits 15..8. A design that took the top bit from bit 15 would insert the wrong bit 7 and report the wrong N.
- Rotations with the carry set and clear. A swapped carry route would put the old bit 0 back at the top instead of the incoming carry.
- A byte exchange requested in byte mode. A design that honoured byte mode there would lose the upper half.
- Sign extension of 0x00 and 0x80 low bytes. These check that C tracks the inverse of Z rather than the shifted-out bit, and that the upper byte fills with ones only when bit 7 is set.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef enum logic [1:0] {
    OP_ROTC = 2'b00,
    OP_SWAP = 2'b01,
    OP_ASHR = 2'b10,
    OP_SEXT = 2'b11
  } ssu_op_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } ssu_flags_t;
endpackage

// File: rtl/ssu_datapath.sv
module ssu_datapath
  import ssu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  ssu_op_e          op,
  input  logic             byte_mode,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             narrow
);
  localparam int HALF = WIDTH / 2;

  logic             is_shift;
  logic             top_in;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] lane_keep;

  assign is_shift = (op == OP_ROTC) || (op == OP_ASHR);
  assign narrow   = is_shift && byte_mode;

  // Bit entering the top position of the active lane
  always_comb begin
    if (op == OP_ROTC) top_in = cin;
    else               top_in = narrow ? a[HALF-1] : a[WIDTH-1];
  end

  // Lane mask: upper half kept only for full-width work
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_lane
      if (gi < HALF) begin : g_lo
        assign lane_keep[gi] = 1'b1;
      end else begin : g_hi
        assign lane_keep[gi] = ~narrow;
      end
    end
  endgenerate

  always_comb begin
    shifted = {1'b0, a[WIDTH-1:1]};
    if (narrow) shifted[HALF-1] = top_in;
    else        shifted[WIDTH-1] = top_in;
    shifted = shifted & lane_keep;
  end

  always_comb begin
    unique case (op)
      OP_SWAP: res = {a[HALF-1:0], a[WIDTH-1:HALF]};
      OP_SEXT: res = {{HALF{a[HALF-1]}}, a[HALF-1:0]};
      default: res = shifted;
    endcase
  end

  assign cout = a[0];
endmodule

// File: rtl/ssu_flags.sv
module ssu_flags
  import ssu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] res,
  input  ssu_op_e          op,
  input  logic             narrow,
  input  logic             shift_out,
  output ssu_flags_t       flags,
  output logic [3:0]       mask
);
  localparam int HALF = WIDTH / 2;

  logic zero, neg;

  assign zero = (res == '0);
  assign neg  = narrow ? res[HALF-1] : res[WIDTH-1];

  always_comb begin
    flags = '0;
    mask  = 4'b0000;
    unique case (op)
      OP_SWAP: begin
        flags = '0;
        mask  = 4'b0000;
      end
      OP_SEXT: begin
        flags.n = neg;
        flags.z = zero;
        flags.c = ~zero;
        mask    = 4'b1111;
      end
      default: begin
        flags.n = neg;
        flags.z = zero;
        flags.c = shift_out;
        mask    = 4'b1111;
      end
    endcase
  end
endmodule

// File: rtl/shift_swap_unit.sv
module shift_swap_unit
  import ssu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [1:0]       op_sel,
  input  logic             byte_mode,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             flag_v,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic [3:0]       flag_mask
);
  ssu_op_e          op;
  logic [WIDTH-1:0] nxt_res;
  logic             nxt_cout;
  logic             nxt_narrow;
  ssu_flags_t       nxt_flags;
  logic [3:0]       nxt_mask;

  assign op = ssu_op_e'(op_sel);

  ssu_datapath #(.WIDTH(WIDTH)) u_dp (
    .a         (op_a),
    .op        (op),
    .byte_mode (byte_mode),
    .cin       (carry_in),
    .res       (nxt_res),
    .cout      (nxt_cout),
    .narrow    (nxt_narrow)
  );

  ssu_flags #(.WIDTH(WIDTH)) u_fl (
    .res       (nxt_res),
    .op        (op),
    .narrow    (nxt_narrow),
    .shift_out (nxt_cout),
    .flags     (nxt_flags),
    .mask      (nxt_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      flag_v    <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
      flag_mask <= 4'b0000;
    end else begin
      result    <= nxt_res;
      flag_v    <= nxt_flags.v;
      flag_n    <= nxt_flags.n;
      flag_z    <= nxt_flags.z;
      flag_c    <= nxt_flags.c;
      flag_mask <= nxt_mask;
    end
  end
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [1:0]       op_sel,
  input logic             byte_mode,
  input logic [WIDTH-1:0] result,
  input logic             flag_v,
  input logic             flag_z,
  input logic             flag_c,
  input logic [3:0]       flag_mask
);
  localparam int HALF = WIDTH / 2;

  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  // R6: byte exchange loads no flags
  assert_swap_nomask_R6: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(op_sel) == 2'b01) |-> (flag_mask == 4'b0000));

  // R9: rotate-through-carry shifts operand bit 0 into C
  assert_rotc_carry_R9: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(op_sel) == 2'b00) |-> (flag_c == $past(op_a[0])));

  // R4: byte-mode shifts clear the upper byte
  assert_byte_hi_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(byte_mode) && !$past(op_sel[0])) |-> (result[WIDTH-1:HALF] == '0));

  // R7: sign extension fills the upper byte with bit 7
  assert_sext_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(op_sel) == 2'b11) |-> (result[WIDTH-1:HALF] == {HALF{result[HALF-1]}}));

  // R8: whenever V is loaded it is zero
  assert_v_clear_R8: assert property (@(posedge clk) disable iff (rst)
    flag_mask[3] |-> !flag_v);

  // R8: loaded Z matches the result
  assert_z_match_R8: assert property (@(posedge clk) disable iff (rst)
    flag_mask[1] |-> (flag_z == (result == '0)));
endmodule

bind shift_swap_unit ssu_checker #(.WIDTH(WIDTH)) u_ssu_checker (
  .clk       (clk),
  .rst       (rst),
  .op_a      (op_a),
  .op_sel    (op_sel),
  .byte_mode (byte_mode),
  .result    (result),
  .flag_v    (flag_v),
  .flag_z    (flag_z),
  .flag_c    (flag_c),
  .flag_mask (flag_mask)
);

// File: tb/tb_shift_swap_unit.sv
`timescale 1ns/1ps
module tb_shift_swap_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] op_a;
  logic [1:0]  op_sel;
  logic        byte_mode;
  logic        carry_in;
  logic [15:0] result;
  logic        flag_v, flag_n, flag_z, flag_c;
  logic [3:0]  flag_mask;

  int applied = 0;
  int bad     = 0;
  int cycles  = 0;
  bit done    = 0;

  always #4 clk = ~clk;  // 125 MHz

  shift_swap_unit dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_sel(op_sel), .byte_mode(byte_mode),
    .carry_in(carry_in), .result(result), .flag_v(flag_v), .flag_n(flag_n),
    .flag_z(flag_z), .flag_c(flag_c), .flag_mask(flag_mask)
  );

  // Packed as {mask[3:0], V, N, Z, C, result[15:0]}
  function automatic logic [23:0] model(input logic [15:0] a, input logic [1:0] op,
                                        input logic bm, input logic ci);
    logic [15:0] r;
    logic        n, z, c;
    logic [3:0]  m;
    bit          nb;
    nb = bm && (op == 2'b00 || op == 2'b10);
    m  = 4'b1111;
    c  = a[0];
    case (op)
      2'b00: r = nb ? {8'h00, ci, a[7:1]} : {ci, a[15:1]};
      2'b10: r = nb ? {8'h00, a[7], a[7:1]} : {a[15], a[15:1]};
      2'b01: r = {a[7:0], a[15:8]};
      default: r = {{8{a[7]}}, a[7:0]};
    endcase
    n = nb ? r[7] : r[15];
    z = (r == 16'h0000);
    if (op == 2'b11) c = ~z;
    if (op == 2'b01) begin
      m = 4'b0000; n = 1'b0; z = 1'b0; c = 1'b0;
    end
    return {m, 1'b0, n, z, c, r};
  endfunction

  function automatic string tag_of(input logic [1:0] op, input logic bm);
    case (op)
      2'b00: return bm ? "R4/R8/R9" : "R2/R8/R9";
      2'b10: return bm ? "R4/R8/R9" : "R3/R8/R9";
      2'b01: return "R5/R6/R7";
      default: return "R7/R8/R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
    applied++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive on a falling edge; R10: the result appears after the next rising edge
  task automatic apply(input logic [15:0] a, input logic [1:0] op,
                       input logic bm, input logic ci);
    op_a = a; op_sel = op; byte_mode = bm; carry_in = ci;
    @(posedge clk);
    @(negedge clk);
    check(tag_of(op, bm), {flag_mask, flag_v, flag_n, flag_z, flag_c, result},
          model(a, op, bm, ci));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 100000) begin
      bad++;
      applied++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5A17);
    rst = 1'b1; op_a = 16'hFFFF; op_sel = 2'b11; byte_mode = 1'b0; carry_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", {flag_mask, flag_v, flag_n, flag_z, flag_c, result}, 24'h0);
    rst = 1'b0;

    // Directed corner cases
    apply(16'h0001, 2'b00, 1'b0, 1'b1);  // R2: carry to top, bit0 out
    apply(16'h0000, 2'b00, 1'b0, 1'b0);  // R2: zero result
    apply(16'h8001, 2'b10, 1'b0, 1'b0);  // R3: top bit kept
    apply(16'hFF01, 2'b00, 1'b1, 1'b1);  // R4: byte rotate, high byte cleared
    apply(16'h1280, 2'b10, 1'b1, 1'b1);  // R4: byte arith shift from bit 7
    apply(16'h12AB, 2'b01, 1'b0, 1'b1);  // R5 R6
    apply(16'h12AB, 2'b01, 1'b1, 1'b0);  // R7: byte mode ignored for exchange
    apply(16'h0080, 2'b11, 1'b1, 1'b0);  // R7 R9: fill ones, C = 1
    apply(16'h7F00, 2'b11, 1'b0, 1'b1);  // R9: zero result, C = 0

    // R10: back-to-back vectors, each visible one edge later
    for (int i = 0; i < 3000; i++) begin
      apply(16'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule